// File: doc/BRIEF.md
# Clause 22 Management Interface Master

This block is a register-driven master for the two-wire station management bus found on Ethernet PHYs. Software places a 16-bit value in a data register, then writes a packed command word that names the PHY, the PHY register, the direction and the range of the system clock. Setting the command word's launch bit starts exactly one clause 22 management frame. The block derives the management clock from the system clock with a divisor chosen by the clock-range code, shifts the frame out MSB first, releases the data line for the turnaround and data phase of reads, and gathers the returned bits.

The launch bit reads back as 1 for the whole frame and drops to 0 when the last bit has gone by. After a read, the data register holds the PHY's answer from that point on. While a frame is in flight the block ignores every write to both registers, so a frame cannot be corrupted halfway through. Extended (clause 45) frames are not generated.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the command word and data register read 0, the launch bit is 0, the management clock output is low and the data-line output enable is low.
- R2: The command word is at byte offset 0x10 with bit 0 = launch/busy, bit 1 = direction (1 write, 0 read), bits 4:2 = clock-range code, bits 10:6 = PHY register, bits 15:11 = PHY address; bit 5 and bits 31:16 read 0. The data register is at 0x14 and holds 16 bits; bits 31:16 read 0. Any other offset reads 0.
- R3: A command write with bit 0 = 1 while idle starts a frame and bit 0 reads 1 until the frame ends; a command write with bit 0 = 0 only updates the stored fields and starts nothing.
- R4: A write frame carries, MSB first: 32 ones, start 01, opcode 01, 5-bit PHY address, 5-bit register, turnaround 10, then the 16 data-register bits; the output enable stays high for all 64 bits and the data register keeps its value.
- R5: A read frame carries 32 ones, 01, opcode 10, PHY address and register; the output enable is low for the last 18 bits (turnaround and data); the 16 bits the PHY returns, MSB first, are in the data register when bit 0 reads 0.
- R6: Data-line changes are launched only as the management clock falls and the line is captured as it rises; each clock period lasts the selected divisor in system clocks with the clock high for half of it, and a frame lasts exactly 64 periods from the launching write to the busy bit clearing.
- R7: The divisors for clock-range codes 0 to 5 are 42, 62, 16, 26, 102 and 124; codes 6 and 7 use 42.
- R8: While a frame is active, writes to the command word and to the data register are ignored: stored fields, the data value and the frame on the wire are unchanged and no further frame starts.
- R9: Between frames the management clock stays low and the data line is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe for one cycle |
| bus_we | input | 1 | 1 for a register write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Data value driven onto the management data line |
| mdio_oe | output | 1 | Drive enable for the management data line |
| mdio_i | input | 1 | Sampled level of the management data line |

## Verification
The hardest situation to reach is a register write arriving in the middle of a frame, since software normally waits for the busy bit. The bench starts a write frame, then in the hundredth and hundred-first cycles of the frame issues a conflicting command word with the launch bit set and a different data value, and afterwards compares the captured wire bits, the frame length and both read-back registers with the original request. Read frames are answered by a bench PHY that drives the line after each falling clock edge, so the release of the output enable and the capture of returned bits are tested together, and the divisor table is swept over all eight codes by counting frame length and high time of the clock.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int MGMT_DATA_W = 16;
    localparam int MGMT_FLD_W  = 5;
    localparam int RANGE_W     = 3;
    localparam int DIV_W       = 8;

    typedef struct packed {
        logic                  wr;
        logic [RANGE_W-1:0]    range;
        logic [MGMT_FLD_W-1:0] regn;
        logic [MGMT_FLD_W-1:0] phy;
    } mgmt_cmd_t;

    // Clock-range code to divisor; unknown codes reuse the code-0 divisor.
    function automatic logic [DIV_W-1:0] range_divisor(input logic [RANGE_W-1:0] code);
        logic [DIV_W-1:0] d;
        case (code)
            3'd1:    d = DIV_W'(62);
            3'd2:    d = DIV_W'(16);
            3'd3:    d = DIV_W'(26);
            3'd4:    d = DIV_W'(102);
            3'd5:    d = DIV_W'(124);
            default: d = DIV_W'(42);
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_mgmt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BUS_W  = 32,
    parameter logic [ADDR_W-1:0] CMD_OFS  = 8'h10,
    parameter logic [ADDR_W-1:0] DATA_OFS = 8'h14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_sel,
    input  logic                   bus_we,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [BUS_W-1:0]       bus_wdata,
    output logic [BUS_W-1:0]       bus_rdata,
    input  logic                   done_i,
    input  logic [MGMT_DATA_W-1:0] rx_data_i,
    output logic                   start_o,
    output mgmt_cmd_t              launch_cmd_o,
    output logic [MGMT_DATA_W-1:0] data_o,
    output mgmt_cmd_t              cmd_o,
    output logic                   busy_o
);

    typedef struct packed {
        logic                   busy;
        mgmt_cmd_t              cmd;
        logic [MGMT_DATA_W-1:0] data;
    } regs_t;

    regs_t q, d;
    logic  cmd_hit, data_hit;
    mgmt_cmd_t wr_fields;

    always_comb begin
        cmd_hit  = bus_sel && bus_we && (bus_addr == CMD_OFS);
        data_hit = bus_sel && bus_we && (bus_addr == DATA_OFS);

        wr_fields.wr    = bus_wdata[1];
        wr_fields.range = bus_wdata[4:2];
        wr_fields.regn  = bus_wdata[10:6];
        wr_fields.phy   = bus_wdata[15:11];

        d       = q;
        start_o = 1'b0;
        if (q.busy) begin
            if (done_i) begin
                d.busy = 1'b0;
                if (!q.cmd.wr) begin
                    d.data = rx_data_i;
                end
            end
        end else begin
            if (cmd_hit) begin
                d.cmd   = wr_fields;
                d.busy  = bus_wdata[0];
                start_o = bus_wdata[0];
            end
            if (data_hit) begin
                d.data = bus_wdata[MGMT_DATA_W-1:0];
            end
        end

        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if (bus_addr == CMD_OFS) begin
                bus_rdata[0]     = q.busy;
                bus_rdata[1]     = q.cmd.wr;
                bus_rdata[4:2]   = q.cmd.range;
                bus_rdata[10:6]  = q.cmd.regn;
                bus_rdata[15:11] = q.cmd.phy;
            end else if (bus_addr == DATA_OFS) begin
                bus_rdata[MGMT_DATA_W-1:0] = q.data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign launch_cmd_o = wr_fields;
    assign data_o       = q.data;
    assign cmd_o        = q.cmd;
    assign busy_o       = q.busy;

    // R8
    cmd_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && cmd_hit) |=> $stable(q.cmd));

    // R8
    data_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !done_i) |=> $stable(q.data));

    // R3
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> $past(done_i));

endmodule

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             mdc_o,
    output logic             rise_o,
    output logic             fall_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } div_t;

    div_t q, d;
    logic [DIV_W-1:0] half_m1;
    logic [DIV_W-1:0] full_m1;

    always_comb begin
        half_m1 = (div_i >> 1) - DIV_W'(1);
        full_m1 = div_i - DIV_W'(1);
        rise_o  = run_i && (q.cnt == half_m1);
        fall_o  = run_i && (q.cnt == full_m1);

        d = q;
        if (!run_i) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (fall_o) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else begin
            d.cnt = q.cnt + DIV_W'(1);
            if (rise_o) begin
                d.mdc = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mdc_o = q.mdc;

    // R6
    mdc_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !rise_o && !fall_o) |=> $stable(q.mdc));

    // R9
    mdc_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !q.mdc);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  mgmt_cmd_t              cmd_i,
    input  logic [MGMT_DATA_W-1:0] wdata_i,
    input  logic                   rise_i,
    input  logic                   fall_i,
    input  logic                   mdio_i,
    output logic                   active_o,
    output logic                   done_o,
    output logic [MGMT_DATA_W-1:0] rx_o,
    output logic                   mdio_o,
    output logic                   mdio_oe_o
);

    localparam int FRAME_LEN = PRE_LEN + 32;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(FRAME_LEN - MGMT_DATA_W - 2);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(FRAME_LEN - MGMT_DATA_W);

    typedef struct packed {
        logic                   active;
        logic                   rd;
        logic [IDX_W-1:0]       idx;
        logic [FRAME_LEN-1:0]   sh;
        logic [MGMT_DATA_W-1:0] rx;
        logic                   mo;
        logic                   oe;
    } seq_t;

    seq_t q, d;
    logic [FRAME_LEN-1:0] frame;
    logic [IDX_W-1:0]     nxt_idx;

    always_comb begin
        frame = {{PRE_LEN{1'b1}}, 2'b01,
                 (cmd_i.wr ? 2'b01 : 2'b10),
                 cmd_i.phy, cmd_i.regn,
                 (cmd_i.wr ? 2'b10 : 2'b00),
                 (cmd_i.wr ? wdata_i : {MGMT_DATA_W{1'b0}})};
        nxt_idx = q.idx + IDX_W'(1);

        d      = q;
        done_o = 1'b0;
        if (!q.active) begin
            if (start_i) begin
                d.active = 1'b1;
                d.rd     = !cmd_i.wr;
                d.idx    = '0;
                d.sh     = frame;
                d.mo     = frame[FRAME_LEN-1];
                d.oe     = 1'b1;
                d.rx     = '0;
            end
        end else begin
            if (rise_i && q.rd && (q.idx >= DAT_IDX)) begin
                d.rx = {q.rx[MGMT_DATA_W-2:0], mdio_i};
            end
            if (fall_i) begin
                if (q.idx == LAST_IDX) begin
                    done_o   = 1'b1;
                    d.active = 1'b0;
                    d.mo     = 1'b0;
                    d.oe     = 1'b0;
                end else begin
                    d.idx = nxt_idx;
                    d.sh  = q.sh << 1;
                    d.mo  = q.sh[FRAME_LEN-2];
                    d.oe  = !(q.rd && (nxt_idx >= TA_IDX));
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign active_o  = q.active;
    assign rx_o      = q.rx;
    assign mdio_o    = q.mo;
    assign mdio_oe_o = q.oe;

    // R6
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && !fall_i) |=> ($stable(q.mo) && $stable(q.idx)));

    // R5
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && q.rd && (q.idx >= TA_IDX)) |-> !q.oe);

    // R4
    write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && !q.rd) |-> q.oe);

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int BUS_W   = 32,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    logic                   start, done, active, busy, rise, fall;
    mgmt_cmd_t              launch_cmd, cmd_q;
    logic [MGMT_DATA_W-1:0] data_q, rx_data;
    logic [DIV_W-1:0]       div_sel;

    mdio_regs #(
        .ADDR_W (ADDR_W),
        .BUS_W  (BUS_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .done_i       (done),
        .rx_data_i    (rx_data),
        .start_o      (start),
        .launch_cmd_o (launch_cmd),
        .data_o       (data_q),
        .cmd_o        (cmd_q),
        .busy_o       (busy)
    );

    assign div_sel = range_divisor(cmd_q.range);

    mdio_clkdiv u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (active),
        .div_i  (div_sel),
        .mdc_o  (mdc),
        .rise_o (rise),
        .fall_o (fall)
    );

    mdio_frame_seq #(
        .PRE_LEN (PRE_LEN)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .cmd_i     (launch_cmd),
        .wdata_i   (data_q),
        .rise_i    (rise),
        .fall_i    (fall),
        .mdio_i    (mdio_i),
        .active_o  (active),
        .done_o    (done),
        .rx_o      (rx_data),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe)
    );

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc));

    // R3
    busy_tracks_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == active);

endmodule

// File: tb/mdio_mgmt_ctrl_bench.sv
module mdio_mgmt_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_bad = 0;

    logic [63:0] cap_o, cap_oe;
    int          f_len, f_hi, f_rises;

    always #10 clk = ~clk;

    mdio_mgmt_ctrl u_mdio_mgmt_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic int div_of(input int code);
        case (code)
            1: return 62;
            2: return 16;
            3: return 26;
            4: return 102;
            5: return 124;
            default: return 42;
        endcase
    endfunction

    function automatic logic [31:0] cmd_word(input logic wr, input int code,
                                             input logic [4:0] phy, input logic [4:0] rg);
        return {16'h0, phy, rg, 1'b0, 3'(code), wr, 1'b1};
    endfunction

    function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] dv);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
                (wr ? 2'b10 : 2'b00), (wr ? dv : 16'h0)};
    endfunction

    // Launch one frame and follow it; the PHY model answers reads with rv.
    task automatic run_frame(input logic [31:0] cmd, input logic [15:0] rv, input logic inject);
        logic rd;
        rd = !cmd[1];
        bus_write(8'h10, cmd);
        fork
            begin
                for (int k = 0; k < 64; k++) begin
                    @(posedge mdc);
                    cap_o[63-k]  = mdio_o;
                    cap_oe[63-k] = mdio_oe;
                    @(negedge mdc);
                    if (rd && (k + 1 >= 47) && (k + 1 <= 63))
                        mdio_i = (k + 1 == 47) ? 1'b0 : rv[63-(k+1)];
                    else
                        mdio_i = 1'b1;
                end
                mdio_i = 1'b1;
            end
            begin
                logic busy_now, mdc_prev;
                f_len = 0; f_hi = 0; f_rises = 0; mdc_prev = 1'b0;
                busy_now = 1'b1;
                while (busy_now && f_len < 20000) begin
                    @(negedge clk);
                    f_len++;
                    if (mdc) f_hi++;
                    if (mdc && !mdc_prev) f_rises++;
                    mdc_prev = mdc;
                    if (inject && f_len == 100) begin
                        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h10;
                        bus_wdata = cmd_word(1'b0, 5, 5'h0A, 5'h15);
                    end else if (inject && f_len == 101) begin
                        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h14;
                        bus_wdata = 32'h0000_0F0F;
                    end else begin
                        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 8'h10;
                        #1 busy_now = bus_rdata[0];
                        bus_sel = 1'b0;
                    end
                end
                bus_sel = 1'b0; bus_we = 1'b0;
            end
        join
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        logic [4:0]  phy, rg;
        logic [15:0] dv;
        logic [31:0] cw;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(8'h10, rv); check("R1 cmd", 64'(rv), 64'h0);
        bus_read(8'h14, rv); check("R1 data", 64'(rv), 64'h0);
        check("R1 mdc/oe", {62'h0, mdc, mdio_oe}, 64'h0);

        // R2 register map and unused bits
        bus_write(8'h14, 32'h1234_ABCD);
        bus_read(8'h14, rv); check("R2 data width", 64'(rv), 64'h0000_ABCD);
        bus_write(8'h10, 32'hFFFF_FFFE);
        bus_read(8'h10, rv); check("R2 R3 cmd fields", 64'(rv), 64'h0000_FFDE);
        bus_read(8'h18, rv); check("R2 other offset", 64'(rv), 64'h0);
        // R3 no frame without launch bit
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (mdc || mdio_oe) seen++;
            end
            check("R3 no frame when bit0=0", 64'(seen), 64'h0);
        end

        // R4 write frames, code 2
        for (int i = 0; i < 6; i++) begin
            phy = 5'((i * 7 + 1) & 31);
            rg  = 5'((i * 11 + 3) & 31);
            dv  = 16'hA5C3 ^ 16'(i * 16'h1357);
            if (i == 0) begin phy = 5'h00; rg = 5'h00; dv = 16'h0000; end
            if (i == 5) begin phy = 5'h1F; rg = 5'h1F; dv = 16'hFFFF; end
            bus_write(8'h14, {16'h0, dv});
            run_frame(cmd_word(1'b1, 2, phy, rg), 16'h0, 1'b0);
            check("R4 write bits", cap_o, exp_frame(1'b1, phy, rg, dv));
            check("R4 write oe", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
            check("R6 frame length", 64'(f_len), 64'(64 * 16));
            check("R6 high time", 64'(f_hi), 64'(32 * 16));
            check("R6 periods", 64'(f_rises), 64'd64);
            bus_read(8'h14, rv); check("R4 data kept", 64'(rv), 64'(dv));
            check("R9 idle after", {62'h0, mdc, mdio_oe}, 64'h0);
        end

        // R5 read frames, code 2
        for (int i = 0; i < 6; i++) begin
            phy = 5'((i * 5 + 2) & 31);
            rg  = 5'((i * 13 + 1) & 31);
            dv  = 16'h3C96 ^ 16'(i * 16'h2469);
            if (i == 0) dv = 16'h0000;
            if (i == 5) begin dv = 16'hFFFF; phy = 5'h1F; rg = 5'h00; end
            run_frame(cmd_word(1'b0, 2, phy, rg), dv, 1'b0);
            check("R5 read header", 64'(cap_o[63:18]), 64'(exp_frame(1'b0, phy, rg, 16'h0) >> 18));
            check("R5 read oe", cap_oe, 64'hFFFF_FFFF_FFFC_0000);
            check("R6 read length", 64'(f_len), 64'(64 * 16));
            bus_read(8'h14, rv); check("R5 read result", 64'(rv), 64'(dv));
            bus_read(8'h10, rv); check("R5 cmd after", 64'(rv), 64'(cmd_word(1'b0, 2, phy, rg) & 32'hFFFF_FFFE));
        end

        // R7 divisor sweep over all codes
        for (int c = 0; c < 8; c++) begin
            dv = 16'(16'h8001 + c * 16'h0111);
            run_frame(cmd_word(1'b0, c, 5'(c), 5'(31 - c)), dv, 1'b0);
            check("R7 frame length", 64'(f_len), 64'(64 * div_of(c)));
            check("R7 high time", 64'(f_hi), 64'(32 * div_of(c)));
            bus_read(8'h14, rv); check("R7 read result", 64'(rv), 64'(dv));
        end

        // R8 writes during a frame are ignored
        dv = 16'h5AA5; phy = 5'h11; rg = 5'h06;
        bus_write(8'h14, {16'h0, dv});
        cw = cmd_word(1'b1, 2, phy, rg);
        run_frame(cw, 16'h0, 1'b1);
        check("R8 wire unchanged", cap_o, exp_frame(1'b1, phy, rg, dv));
        check("R8 no restart", 64'(f_len), 64'(64 * 16));
        bus_read(8'h10, rv); check("R8 cmd unchanged", 64'(rv), 64'(cw & 32'hFFFF_FFFE));
        bus_read(8'h14, rv); check("R8 data unchanged", 64'(rv), 64'(dv));
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (mdc || mdio_oe) seen++;
            end
            check("R9 quiet between frames", 64'(seen), 64'h0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule